// File: doc/BRIEF.md
# Five-Band Sidetone Equalizer

This block shapes a sidetone signal before it is mixed back into a listener's earpiece. It picks one of several audio sources, scales the chosen sample by a signed gain in decibel steps, and passes the result through five second-order recursive filter sections in series. Each section takes its five coefficients from a coefficient store outside the block, presented as one flat vector, and each can be switched off on its own so that it passes samples through untouched.

Samples arrive one per input strobe. The result of each strobe leaves exactly one cycle per section later with its own one-cycle output strobe. Between strobes the output sample holds its last value. All arithmetic is signed fixed point. The gain stage and every section clip their results to the 24-bit sample range instead of wrapping.

Top module: `sidetone_eq`

## Requirements
- R1: `src_sel` picks the filter input when `in_valid` is high. 1 selects `dec_samples[23:0]`, 2 selects `dec_samples[47:24]`, 3, 4 and 5 select `rx_samples[23:0]`, `[47:24]` and `[71:48]`. Codes 0, 6 and 7 feed a constant zero.
- R2: `gain_db` is first clamped to the range -84..+40. With g the clamped value, write g + 84 = 6*k + r where r is 0..5. The gain is then M[r] * 2^(k-14) / 32768, with M = {32768, 36766, 41252, 46286, 51935, 58271}. The scaled sample is floor(x * M[r] * 2^(k-14) / 32768). A gain of 0 passes the sample unchanged.
- R3: A scaled sample outside -8388608..8388607 is clipped to the nearer limit.
- R4: An enabled section computes floor((b0*x + b1*x1 + b2*x2 - a1*y1 - a2*y2) / 2^28) and clips the result to 24 bits. Here x1 and x2 are its two previous inputs and y1 and y2 its two previous outputs. Coefficients are 30-bit two's complement with 28 fractional bits. Coefficient k of band n (n = 0..4, k = 0..4 in the order b0, b1, b2, a1, a2) sits at `coefs[(5*n+k)*30 +: 30]`.
- R5: `band_en[n]` enables band n+1. A band whose bit is 0 passes its input sample through unchanged.
- R6: While a band is disabled, its stored inputs and outputs are held at zero. When it is enabled again, it starts from rest.
- R7: `out_valid` rises exactly 5 cycles after each accepted `in_valid` and lasts one cycle per strobe. Back-to-back strobes give back-to-back results.
- R8: After reset, `out_valid` and `out_sample` are 0. `out_sample` changes only in a cycle where `out_valid` is high.
- R9: Samples pass band 1 first and band 5 last. Each enabled band clips its own output before the next band sees it.
- R10: Filter state advances only on strobes. Changes on the data, select and gain inputs while `in_valid` is low have no effect on later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| src_sel | input | 3 | Source selector code |
| dec_samples | input | 48 | Two decimator channels, channel 1 in the low bits |
| rx_samples | input | 72 | Three receive paths, path 1 in the low bits |
| gain_db | input | 8 | Signed input gain in dB |
| band_en | input | 5 | Per-band enable, bit 0 for band 1 |
| coefs | input | 750 | Flat coefficient vector for all bands |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 24 | Filtered signed sample |

## Verification
The hardest case to reach from the ports is a band that is switched off while its recursive state is still ringing and then switched back on. The output only reveals whether its state was cleared if the next sample is zero and would otherwise carry the leftover echo. The bench first primes band 2 with an impulse. It then reads the decaying tail, sends a zero sample with the band off, and sends another zero sample with the band back on. It expects silence where a band with stale state would ring. Clipping inside the cascade is reached with a band whose leading coefficient exceeds one, fed with a near-full-scale sample. Clamping of out-of-range gain codes is reached by driving the extreme values of the 8-bit field.

// File: rtl/steq_pkg.sv
package steq_pkg;

    localparam int SAMPLE_W    = 24;
    localparam int COEF_W      = 30;
    localparam int COEF_FRAC   = 28;
    localparam int N_BANDS     = 5;
    localparam int N_TAPS      = 5;
    localparam int SEL_W       = 3;
    localparam int GAIN_W      = 8;
    localparam int N_DEC       = 2;
    localparam int N_RX        = 3;
    localparam int MANT_W      = 16;
    localparam int MANT_FRAC   = 15;
    localparam int GAIN_MIN    = -84;
    localparam int GAIN_MAX    = 40;
    localparam int DB_PER_OCT  = 6;
    localparam int ACC_W       = 64;
    localparam int PROD_W      = COEF_W + SAMPLE_W;
    localparam int GPROD_W     = SAMPLE_W + MANT_W + 1;
    localparam int COEF_BITS   = N_BANDS * N_TAPS * COEF_W;

    localparam logic signed [ACC_W-1:0] SAT_HI = (64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1;
    localparam logic signed [ACC_W-1:0] SAT_LO = -(64'sd1 <<< (SAMPLE_W - 1));

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;

    typedef enum logic [SEL_W-1:0] {
        SRC_ZERO = 3'd0,
        SRC_DEC1 = 3'd1,
        SRC_DEC2 = 3'd2,
        SRC_RX1  = 3'd3,
        SRC_RX2  = 3'd4,
        SRC_RX3  = 3'd5
    } src_e;

    typedef struct packed {
        coef_t b0;
        coef_t b1;
        coef_t b2;
        coef_t a1;
        coef_t a2;
    } biquad_coef_t;

    typedef struct packed {
        logic    vld;
        sample_t data;
    } beat_t;

    typedef struct packed {
        sample_t x1;
        sample_t x2;
        sample_t y1;
        sample_t y2;
    } biquad_state_t;

    function automatic logic [MANT_W-1:0] mant_lut(input int r);
        case (r)
            1:       return 16'd36766;
            2:       return 16'd41252;
            3:       return 16'd46286;
            4:       return 16'd51935;
            5:       return 16'd58271;
            default: return 16'd32768;
        endcase
    endfunction

    function automatic sample_t sat_sample(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] c;
        if (v > SAT_HI)      c = SAT_HI;
        else if (v < SAT_LO) c = SAT_LO;
        else                 c = v;
        return c[SAMPLE_W-1:0];
    endfunction

    function automatic logic signed [ACC_W-1:0] mac_term(input coef_t c, input sample_t s);
        logic signed [PROD_W-1:0] p;
        p = c * s;
        return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
    endfunction

endpackage

// File: rtl/steq_source_gain.sv
module steq_source_gain
    import steq_pkg::*;
(
    input  logic [SEL_W-1:0]           src_sel,
    input  logic [N_DEC*SAMPLE_W-1:0]  dec_samples,
    input  logic [N_RX*SAMPLE_W-1:0]   rx_samples,
    input  logic signed [GAIN_W-1:0]   gain_db,
    output sample_t                    gained
);

    sample_t                    picked;
    logic [MANT_W-1:0]          mant;
    logic signed [GPROD_W-1:0]  prod;
    logic signed [GPROD_W-1:0]  prod_sh;
    logic signed [ACC_W-1:0]    wide;
    int                         g_clamped;
    int                         idx;
    int                         octave;
    int                         rem;
    int                         shamt;

    always_comb begin
        case (src_e'(src_sel))
            SRC_DEC1: picked = dec_samples[0*SAMPLE_W +: SAMPLE_W];
            SRC_DEC2: picked = dec_samples[1*SAMPLE_W +: SAMPLE_W];
            SRC_RX1:  picked = rx_samples[0*SAMPLE_W +: SAMPLE_W];
            SRC_RX2:  picked = rx_samples[1*SAMPLE_W +: SAMPLE_W];
            SRC_RX3:  picked = rx_samples[2*SAMPLE_W +: SAMPLE_W];
            default:  picked = '0;
        endcase
    end

    always_comb begin
        g_clamped = int'(gain_db);
        if (g_clamped < GAIN_MIN) g_clamped = GAIN_MIN;
        if (g_clamped > GAIN_MAX) g_clamped = GAIN_MAX;
        idx    = g_clamped - GAIN_MIN;
        octave = idx / DB_PER_OCT;
        rem    = idx % DB_PER_OCT;
        shamt  = MANT_FRAC - (octave + GAIN_MIN / DB_PER_OCT);
        mant   = mant_lut(rem);
    end

    always_comb begin
        prod    = picked * $signed({1'b0, mant});
        prod_sh = prod >>> shamt;
        wide    = {{(ACC_W-GPROD_W){prod_sh[GPROD_W-1]}}, prod_sh};
        gained  = sat_sample(wide);
    end

endmodule

// File: rtl/steq_biquad.sv
module steq_biquad
    import steq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  biquad_coef_t  coef,
    input  beat_t         beat_in,
    output beat_t         beat_out
);

    biquad_state_t            st;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  acc_sh;
    sample_t                  y_new;

    always_comb begin
        acc = mac_term(coef.b0, beat_in.data)
            + mac_term(coef.b1, st.x1)
            + mac_term(coef.b2, st.x2)
            - mac_term(coef.a1, st.y1)
            - mac_term(coef.a2, st.y2);
        acc_sh = acc >>> COEF_FRAC;
        y_new  = sat_sample(acc_sh);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            beat_out <= '0;
        end else begin
            beat_out.vld <= beat_in.vld;
            if (!en) begin
                st <= '0;
                if (beat_in.vld) beat_out.data <= beat_in.data;
            end else if (beat_in.vld) begin
                beat_out.data <= y_new;
                st.x2         <= st.x1;
                st.x1         <= beat_in.data;
                st.y2         <= st.y1;
                st.y1         <= y_new;
            end
        end
    end

endmodule

// File: rtl/steq_cascade.sv
module steq_cascade
    import steq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_BANDS-1:0]   band_en,
    input  logic [COEF_BITS-1:0] coefs,
    input  beat_t                head,
    output beat_t                tail
);

    localparam int BAND_BITS = N_TAPS * COEF_W;

    beat_t chain [N_BANDS+1];

    assign chain[0] = head;

    for (genvar n = 0; n < N_BANDS; n++) begin : g_band
        biquad_coef_t c;
        logic [BAND_BITS-1:0] slot;

        assign slot = coefs[n*BAND_BITS +: BAND_BITS];
        assign c.b0 = slot[0*COEF_W +: COEF_W];
        assign c.b1 = slot[1*COEF_W +: COEF_W];
        assign c.b2 = slot[2*COEF_W +: COEF_W];
        assign c.a1 = slot[3*COEF_W +: COEF_W];
        assign c.a2 = slot[4*COEF_W +: COEF_W];

        steq_biquad u_sec (
            .clk      (clk),
            .rst      (rst),
            .en       (band_en[n]),
            .coef     (c),
            .beat_in  (chain[n]),
            .beat_out (chain[n+1])
        );
    end

    assign tail = chain[N_BANDS];

endmodule

// File: rtl/sidetone_eq.sv
module sidetone_eq
    import steq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [2:0]                    src_sel,
    input  logic [47:0]                   dec_samples,
    input  logic [71:0]                   rx_samples,
    input  logic signed [7:0]             gain_db,
    input  logic [4:0]                    band_en,
    input  logic [749:0]                  coefs,
    output logic                          out_valid,
    output logic signed [23:0]            out_sample
);

    sample_t gained;
    beat_t   head;
    beat_t   tail;

    steq_source_gain u_front (
        .src_sel     (src_sel),
        .dec_samples (dec_samples),
        .rx_samples  (rx_samples),
        .gain_db     (gain_db),
        .gained      (gained)
    );

    assign head.vld  = in_valid;
    assign head.data = gained;

    steq_cascade u_chain (
        .clk     (clk),
        .rst     (rst),
        .band_en (band_en),
        .coefs   (coefs),
        .head    (head),
        .tail    (tail)
    );

    assign out_valid  = tail.vld;
    assign out_sample = tail.data;

endmodule

// File: rtl/sidetone_eq_chk.sv
module sidetone_eq_chk
    import steq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [2:0]         src_sel,
    input  logic [47:0]        dec_samples,
    input  logic [71:0]        rx_samples,
    input  logic signed [7:0]  gain_db,
    input  logic [4:0]         band_en,
    input  logic               out_valid,
    input  logic signed [23:0] out_sample
);

    logic [N_BANDS-1:0] vp;
    logic [N_BANDS-1:0] unity;
    logic [N_BANDS-1:0] silent;
    sample_t            dp [N_BANDS];
    sample_t            raw;
    logic               zero_code;
    logic               all_off;

    always_comb begin
        zero_code = 1'b0;
        case (src_sel)
            3'd1:    raw = dec_samples[23:0];
            3'd2:    raw = dec_samples[47:24];
            3'd3:    raw = rx_samples[23:0];
            3'd4:    raw = rx_samples[47:24];
            3'd5:    raw = rx_samples[71:48];
            default: begin raw = '0; zero_code = 1'b1; end
        endcase
        all_off = (band_en == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vp     <= '0;
            unity  <= '0;
            silent <= '0;
            for (int i = 0; i < N_BANDS; i++) dp[i] <= '0;
        end else begin
            vp[0]     <= in_valid;
            unity[0]  <= in_valid && all_off && (gain_db == 8'sd0);
            silent[0] <= in_valid && all_off && zero_code;
            dp[0]     <= raw;
            for (int i = 1; i < N_BANDS; i++) begin
                vp[i]     <= vp[i-1];
                unity[i]  <= unity[i-1] && all_off;
                silent[i] <= silent[i-1] && all_off;
                dp[i]     <= dp[i-1];
            end
        end
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == vp[N_BANDS-1]); // R7

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_sample)); // R8

    AST_UNITY_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && unity[N_BANDS-1]) |-> (out_sample == dp[N_BANDS-1])); // R5

    AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && silent[N_BANDS-1]) |-> (out_sample == 24'sd0)); // R1

endmodule

bind sidetone_eq sidetone_eq_chk u_chk (.*);

// File: tb/sidetone_eq_test.sv
module sidetone_eq_test;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [2:0]         src_sel = '0;
    logic [47:0]        dec_samples = '0;
    logic [71:0]        rx_samples = '0;
    logic signed [7:0]  gain_db = '0;
    logic [4:0]         band_en = '0;
    logic [749:0]       coefs = '0;
    logic               out_valid;
    logic signed [23:0] out_sample;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    longint cf [5][5];
    longint mx1 [5];
    longint mx2 [5];
    longint my1 [5];
    longint my2 [5];
    longint last_exp = 0;

    localparam int NV = 16;
    // fields: sel[43:41] gain[40:33] en[32:28] sample[27:4] idle[3:0]
    localparam logic [43:0] VEC [NV] = '{
        {3'd1, 8'(0),   5'b00000, 24'(1000),     4'd0},
        {3'd2, 8'(0),   5'b00000, 24'(-2000),    4'd1},
        {3'd3, 8'(6),   5'b00000, 24'(3000),     4'd2},
        {3'd4, 8'(-6),  5'b00000, 24'(3000),     4'd0},
        {3'd5, 8'(3),   5'b00000, 24'(4096),     4'd3},
        {3'd0, 8'(0),   5'b00000, 24'(7777),     4'd1},
        {3'd6, 8'(12),  5'b00000, 24'(7777),     4'd0},
        {3'd1, 8'(0),   5'b00001, 24'(4000),     4'd2},
        {3'd1, 8'(0),   5'b00001, 24'(0),        4'd0},
        {3'd1, 8'(0),   5'b00011, 24'(8000),     4'd1},
        {3'd3, 8'(-20), 5'b11111, 24'(500000),   4'd0},
        {3'd4, 8'(1),   5'b11111, 24'(-120000),  4'd2},
        {3'd5, 8'(0),   5'b11111, 24'(0),        4'd1},
        {3'd2, 8'(-1),  5'b10100, 24'(-3000000), 4'd0},
        {3'd1, 8'(5),   5'b10100, 24'(250000),   4'd3},
        {3'd7, 8'(0),   5'b10100, 24'(99999),    4'd0}
    };

    sidetone_eq uut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .src_sel     (src_sel),
        .dec_samples (dec_samples),
        .rx_samples  (rx_samples),
        .gain_db     (gain_db),
        .band_en     (band_en),
        .coefs       (coefs),
        .out_valid   (out_valid),
        .out_sample  (out_sample)
    );

    always #5 clk = ~clk;

    function automatic longint sat24(input longint v);
        if (v > 64'sd8388607)  return 64'sd8388607;
        if (v < -64'sd8388608) return -64'sd8388608;
        return v;
    endfunction

    function automatic longint gain_model(input longint x, input int g);
        longint m [6] = '{32768, 36766, 41252, 46286, 51935, 58271};
        int gc;
        int k;
        int r;
        gc = g;
        if (gc < -84) gc = -84;
        if (gc > 40)  gc = 40;
        r = (gc + 84) % 6;
        k = (gc + 84) / 6;
        return sat24((x * m[r]) >>> (29 - k));
    endfunction

    function automatic longint src_model(input logic [2:0] sel, input longint s);
        if (sel >= 3'd1 && sel <= 3'd5) return s;
        return 0;
    endfunction

    task automatic model_step(input longint xin, input logic [4:0] en, output longint yout);
        longint x;
        longint acc;
        longint y;
        x = xin;
        for (int b = 0; b < 5; b++) begin
            if (en[b]) begin
                acc = cf[b][0] * x + cf[b][1] * mx1[b] + cf[b][2] * mx2[b]
                    - cf[b][3] * my1[b] - cf[b][4] * my2[b];
                y = sat24(acc >>> 28);
                mx2[b] = mx1[b]; mx1[b] = x;
                my2[b] = my1[b]; my1[b] = y;
                x = y;
            end else begin
                mx1[b] = 0; mx2[b] = 0; my1[b] = 0; my2[b] = 0;
            end
        end
        yout = x;
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_sources(input logic [2:0] sel, input longint s);
        dec_samples = {24'(222), 24'(111)};
        rx_samples  = {24'(555), 24'(444), 24'(333)};
        case (sel)
            3'd1: dec_samples[23:0]  = 24'(s);
            3'd2: dec_samples[47:24] = 24'(s);
            3'd3: rx_samples[23:0]   = 24'(s);
            3'd4: rx_samples[47:24]  = 24'(s);
            3'd5: rx_samples[71:48]  = 24'(s);
            default: begin
                dec_samples = {24'(s), 24'(s)};
                rx_samples  = {24'(s), 24'(s), 24'(s)};
            end
        endcase
    endtask

    task automatic apply(input logic [2:0] sel, input int g, input logic [4:0] en,
                         input longint s, input string tag);
        longint e;
        @(negedge clk);
        set_sources(sel, s);
        src_sel  = sel;
        gain_db  = 8'(g);
        band_en  = en;
        in_valid = 1'b1;
        model_step(gain_model(src_model(sel, s), g), en, e);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({tag, " R7 early valid"}, longint'(out_valid), 0);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R7 valid"}, longint'(out_valid), 1);
        check({tag, " data"}, longint'(out_sample), e);
        last_exp = e;
    endtask

    task automatic idle_noise(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dec_samples = {24'(i * 7919 + 13), 24'(i * 104729 + 5)};
            rx_samples  = {24'(-i * 31), 24'(i * 6007), 24'(i * 99991)};
            src_sel     = 3'(i + 1);
            gain_db     = 8'(i * 9);
        end
    endtask

    initial begin
        cf[0] = '{64'sd268435456, 64'sd134217728, 64'sd0, 64'sd0, 64'sd0};
        cf[1] = '{64'sd134217728, 64'sd0, 64'sd0, -64'sd134217728, 64'sd0};
        cf[2] = '{64'sd268435456, -64'sd268435456, 64'sd67108864, 64'sd0, 64'sd0};
        cf[3] = '{64'sd402653184, 64'sd0, 64'sd67108864, 64'sd0, 64'sd67108864};
        cf[4] = '{64'sd201326592, 64'sd67108864, 64'sd33554432, 64'sd33554432, -64'sd16777216};
        for (int b = 0; b < 5; b++) begin
            mx1[b] = 0; mx2[b] = 0; my1[b] = 0; my2[b] = 0;
            for (int k = 0; k < 5; k++)
                coefs[(b * 5 + k) * 30 +: 30] = cf[b][k][29:0];
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset valid", longint'(out_valid), 0);
        check("R8 reset data", longint'(out_sample), 0);

        // vector table: R1 R2 R4 R5 R9 R10
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][43:41], int'($signed(VEC[v][40:33])), VEC[v][32:28],
                  longint'($signed(VEC[v][27:4])), $sformatf("R1/R2/R4/R5/R9 vec%0d", v));
            idle_noise(int'(VEC[v][3:0]));
        end

        // R3 gain saturation with all bands off
        apply(3'd1, 40, 5'b00000, 64'sd8388607, "R3 high");
        check("R3 high clip", longint'(out_sample), 64'sd8388607);
        apply(3'd1, 40, 5'b00000, -64'sd8388608, "R3 low");
        check("R3 low clip", longint'(out_sample), -64'sd8388608);

        // R2 gain clamp at the field extremes
        apply(3'd1, 127, 5'b00000, 64'sd1000, "R2 clamp top");
        check("R2 clamp top value", longint'(out_sample), 64'sd101435);
        apply(3'd1, -128, 5'b00000, 64'sd8000000, "R2 clamp bottom");
        check("R2 clamp bottom value", longint'(out_sample), 64'sd488);

        // R4 / R9 section clipping with gain above one
        apply(3'd1, 0, 5'b01000, 64'sd8000000, "R4 R9 section clip");
        check("R4 section clip value", longint'(out_sample), 64'sd8388607);

        // R8 hold and R10 ignored idle inputs
        idle_noise(4);
        @(negedge clk);
        check("R8 hold valid", longint'(out_valid), 0);
        check("R10 hold data", longint'(out_sample), last_exp);

        // R6 disable clears ringing state
        apply(3'd1, 0, 5'b00010, 64'sd10000, "R6 prime");
        apply(3'd1, 0, 5'b00010, 64'sd0, "R6 ring");
        check("R6 ring nonzero", longint'(out_sample != 0), 1);
        apply(3'd1, 0, 5'b00000, 64'sd0, "R6 off");
        apply(3'd1, 0, 5'b00010, 64'sd0, "R6 from rest");
        check("R6 rest value", longint'(out_sample), 0);

        // R7 back-to-back streaming through all bands
        begin
            longint exq [8];
            longint smp [8] = '{64'sd70000, -64'sd30000, 64'sd0, 64'sd1234567,
                                -64'sd999, 64'sd42, 64'sd0, -64'sd7000000};
            for (int i = 0; i < 13; i++) begin
                @(negedge clk);
                if (i >= 5) begin
                    check($sformatf("R7 stream valid %0d", i - 5), longint'(out_valid), 1);
                    check($sformatf("R7 R9 stream data %0d", i - 5), longint'(out_sample), exq[i - 5]);
                end
                if (i < 8) begin
                    set_sources(3'd4, smp[i]);
                    src_sel  = 3'd4;
                    gain_db  = 8'(2);
                    band_en  = 5'b11111;
                    in_valid = 1'b1;
                    model_step(gain_model(smp[i], 2), 5'b11111, exq[i]);
                end else begin
                    in_valid = 1'b0;
                end
            end
            @(negedge clk);
            check("R7 stream end", longint'(out_valid), 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R7 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule